// File: doc/BRIEF.md
# Triggered Multi-Event Sample Buffer

This block records the 10-bit samples of one detector channel into a single 1024 x 40-bit event memory. A first-level trigger opens an acquisition window. The window is fixed at a set number of sample strobes, 1008 by default. Inside the window, each strobed sample is either kept or dropped. In raw mode every sample is kept. Otherwise a sample that upstream zero suppression has flagged is dropped. Kept samples are packed four to a 40-bit word. When the window closes, a header word is written in front of the data. The header gives the timestamp of the trigger and the number of samples kept.

A finished stream is kept only when a second-level accept arrives. The accept may come during the window, after the window, or in the same cycle as the next first-level trigger. If the next first-level trigger arrives first, the stream is thrown away and its memory is reused at once. Accepted streams form a circular queue. A reader drains that queue word by word, in order.

Before a stream starts, the block checks that room is left for a stream of full length. If there is not enough room, the trigger is refused and a sticky overflow flag is set.

Top module: `evt_sample_buffer`

## Requirements
- R1: After reset, `full`, `overflow`, `rd_avail` and `rd_valid` are all 0.
- R2: A `l1_trig` taken while no stream is being captured starts a stream. The stream covers the next WIN_LEN cycles with `smp_valid` high (1008 by default). Strobes outside a stream store nothing, and `l1_trig` during a capture is ignored.
- R3: A strobed sample is stored when `raw_mode` is 1 or `smp_suppressed` is 0. Any other strobed sample is dropped.
- R4: Stored samples are packed four per data word. The earliest sample goes in bits [9:0], then [19:10], [29:20] and [39:30]. A final partial word has its unused slots set to zero. A stream with no stored samples has no data words.
- R5: Each stream starts with a header word. Bits [9:0] hold the number of stored samples. Bits [39:10] hold the timestamp: the number of clock cycles from reset release to the cycle in which `l1_trig` was sampled, modulo 2^30.
- R6: A stream is kept when `l2_accept` is high in any cycle after its trigger and before the next accepted `l1_trig`. This covers cycles during capture and cycles after capture.
- R7: A pending stream with no accept is dropped by the next `l1_trig`. None of its words ever become readable, and the new stream reuses its space.
- R8: When `l1_trig` and `l2_accept` are high in the same cycle while a stream waits, the waiting stream is kept and a new stream starts.
- R9: `full` is high when fewer than 1+ceil(WIN_LEN/4) words (253 by default) are free, counting only accepted, unread words as used. A `l1_trig` that would start a stream while that room is missing is refused, and `overflow` is set and stays set until reset.
- R10: `rd_en` while `rd_avail` is high returns the next accepted word one cycle later, with `rd_valid` high. `rd_avail` covers only accepted streams, and `rd_en` without `rd_avail` returns nothing.
- R11: Four full-length raw streams fit in the memory at once, as do eight streams that keep about a fifth of their samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l1_trig | input | 1 | First-level trigger, starts a stream |
| l2_accept | input | 1 | Second-level accept, keeps the current stream |
| raw_mode | input | 1 | 1: store every strobed sample |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 10 | Sample value |
| smp_suppressed | input | 1 | Upstream suppression flag for this sample |
| rd_en | input | 1 | Read request |
| rd_avail | output | 1 | Accepted words are waiting |
| rd_valid | output | 1 | `rd_data` holds a word this cycle |
| rd_data | output | 40 | Word read from the event memory |
| full | output | 1 | Not enough room for another full-length stream |
| overflow | output | 1 | Sticky: a trigger was refused |

## Verification
The bench uses random sample values with gaps in the strobe and random suppression rates, in both raw and filtered modes. This shows whether the keep rule, the slot order, the zero padding and the header count agree. Accepts come in three ways: during capture, after capture, and in the same cycle as the next trigger. Running all three separates the keep, discard and reuse paths. Directed runs add a stream with no stored samples, eight sparse streams held at once, and four full raw streams followed by a refused trigger. These show the capacity limit, the refusal of a trigger and the sticky overflow.

// File: rtl/evb_pkg.sv
package evb_pkg;
  localparam int SMP_W  = 10;
  localparam int WORD_W = 40;
  localparam int SLOTS  = WORD_W / SMP_W;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int LEN_W  = 10;
  localparam int TS_W   = WORD_W - LEN_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [SMP_W-1:0]  smp_t;

  typedef enum logic [1:0] {ST_IDLE, ST_CAPT, ST_HDR, ST_PEND} st_e;

  // header: timestamp above, stored-sample count in the low field
  function automatic word_t make_header(logic [TS_W-1:0] ts, logic [LEN_W-1:0] len);
    return {ts, len};
  endfunction

  // drop one sample into its slot of a data word
  function automatic word_t put_slot(word_t w, logic [SLOT_W-1:0] idx, smp_t s);
    word_t r;
    r = w;
    r[int'(idx)*SMP_W +: SMP_W] = s;
    return r;
  endfunction

  // worst-case words one stream occupies: header plus packed data
  function automatic int event_words(int win);
    return 1 + (win + SLOTS - 1) / SLOTS;
  endfunction
endpackage

// File: rtl/evb_ram.sv
module evb_ram
  import evb_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/evb_packer.sv
module evb_packer
  import evb_pkg::*;
#(
  parameter int WIN_LEN = 1008,
  localparam int CNT_W = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             active,
  input  logic             smp_valid,
  input  smp_t             smp_data,
  input  logic             smp_take,
  output logic             word_fire,
  output word_t            word_data,
  output logic             last_fire,
  output logic [LEN_W-1:0] len_o
);
  word_t             buf_q;
  logic [SLOT_W-1:0] slot_q;
  logic [CNT_W-1:0]  win_q;
  logic [LEN_W-1:0]  len_q;

  logic  strobe, take, slot_full, has_data;
  word_t merged;

  always_comb begin
    strobe    = active & smp_valid;
    take      = strobe & smp_take;
    merged    = take ? put_slot(buf_q, slot_q, smp_data) : buf_q;
    last_fire = strobe & (win_q == CNT_W'(WIN_LEN - 1));
    slot_full = take & (slot_q == SLOT_W'(SLOTS - 1));
    has_data  = take | (slot_q != '0);
    word_fire = slot_full | (last_fire & has_data);
    word_data = merged;
  end

  assign len_o = len_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      buf_q  <= '0;
      slot_q <= '0;
      win_q  <= '0;
      len_q  <= '0;
    end else if (strobe) begin
      win_q <= win_q + 1'b1;
      if (take) len_q <= len_q + 1'b1;
      if (word_fire) begin
        buf_q  <= '0;
        slot_q <= '0;
      end else if (take) begin
        buf_q  <= merged;
        slot_q <= slot_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/evt_sample_buffer.sv
module evt_sample_buffer
  import evb_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int WIN_LEN = 1008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l1_trig,
  input  logic              l2_accept,
  input  logic              raw_mode,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              smp_suppressed,
  input  logic              rd_en,
  output logic              rd_avail,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              full,
  output logic              overflow
);
  localparam int AW   = $clog2(DEPTH);
  localparam int PW   = AW + 1;
  localparam int NEED = event_words(WIN_LEN);

  st_e              state_q;
  logic [PW-1:0]    wr_q, start_q, commit_q, rd_q;
  logic [TS_W-1:0]  ts_q, evt_ts_q;
  logic             keep_q, ovf_q, rd_valid_q;

  // named internal events
  logic          ev_start, ev_reject, ev_discard, ev_commit;
  logic          data_wr, hdr_wr, rd_fire, may_start, pend_l2, room;
  logic [PW-1:0] base;

  logic             pk_word_fire, pk_last;
  word_t            pk_word;
  logic [LEN_W-1:0] pk_len;

  logic          ram_we;
  logic [AW-1:0] ram_waddr;
  word_t         ram_wdata;

  function automatic logic [PW-1:0] free_of(logic [PW-1:0] b, logic [PW-1:0] r);
    return PW'(DEPTH) - (b - r);
  endfunction

  always_comb begin
    may_start  = (state_q == ST_IDLE) | (state_q == ST_PEND);
    pend_l2    = (state_q == ST_PEND) & l2_accept;
    base       = pend_l2 ? wr_q : commit_q;
    room       = free_of(base, rd_q) >= PW'(NEED);
    ev_start   = l1_trig & may_start & room;
    ev_reject  = l1_trig & may_start & ~room;
    ev_discard = (state_q == ST_PEND) & l1_trig & ~l2_accept;
    ev_commit  = ((state_q == ST_HDR) & (keep_q | l2_accept)) | pend_l2;
    data_wr    = pk_word_fire;
    hdr_wr     = (state_q == ST_HDR);
    rd_avail   = (rd_q != commit_q);
    rd_fire    = rd_en & rd_avail;
    full       = free_of(commit_q, rd_q) < PW'(NEED);
    ram_we     = data_wr | hdr_wr;
    ram_waddr  = hdr_wr ? start_q[AW-1:0] : wr_q[AW-1:0];
    ram_wdata  = hdr_wr ? make_header(evt_ts_q, pk_len) : pk_word;
  end

  assign overflow = ovf_q;
  assign rd_valid = rd_valid_q;

  evb_packer #(.WIN_LEN(WIN_LEN)) packer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (ev_start),
    .active    (state_q == ST_CAPT),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .smp_take  (raw_mode | ~smp_suppressed),
    .word_fire (pk_word_fire),
    .word_data (pk_word),
    .last_fire (pk_last),
    .len_o     (pk_len)
  );

  evb_ram #(.DEPTH(DEPTH)) ram_i (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (rd_fire),
    .raddr (rd_q[AW-1:0]),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      wr_q       <= '0;
      start_q    <= '0;
      commit_q   <= '0;
      rd_q       <= '0;
      ts_q       <= '0;
      evt_ts_q   <= '0;
      keep_q     <= 1'b0;
      ovf_q      <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      ts_q       <= ts_q + 1'b1;
      rd_valid_q <= rd_fire;
      if (rd_fire) rd_q <= rd_q + 1'b1;
      if (data_wr) wr_q <= wr_q + 1'b1;
      if (ev_reject) ovf_q <= 1'b1;
      if (ev_commit) commit_q <= wr_q;

      unique case (state_q)
        ST_CAPT: begin
          if (l2_accept) keep_q <= 1'b1;
          if (pk_last) state_q <= ST_HDR;
        end
        ST_HDR: state_q <= (keep_q | l2_accept) ? ST_IDLE : ST_PEND;
        ST_IDLE, ST_PEND: begin
          if (pend_l2) state_q <= ST_IDLE;
          if (ev_start) begin
            start_q  <= base;
            wr_q     <= base + 1'b1;
            evt_ts_q <= ts_q;
            keep_q   <= 1'b0;
            state_q  <= ST_CAPT;
          end else if (ev_reject) begin
            wr_q    <= base;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evb_checker.sv
module evb_checker #(
  parameter int PW    = 11,
  parameter int DEPTH = 1024
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l2_accept,
  input logic          rd_en,
  input logic          rd_avail,
  input logic          rd_valid,
  input logic          overflow,
  input logic [PW-1:0] wr_q,
  input logic [PW-1:0] rd_q,
  input logic [PW-1:0] commit_q,
  input logic          keep_q,
  input logic          ev_commit,
  input logic          ev_discard,
  input logic          ev_reject,
  input logic          data_wr,
  input logic          hdr_wr
);
  logic [PW-1:0] occ;
  assign occ = wr_q - rd_q;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R9
  AST_REJECT_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> overflow); // R9
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PW'(DEPTH)); // R11
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_avail) |=> rd_valid); // R10
  AST_NO_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_avail) |=> !rd_valid); // R10
  AST_DISCARD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_discard |=> $stable(commit_q)); // R7
  AST_COMMIT_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |-> (keep_q || l2_accept)); // R6
  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_wr && hdr_wr)); // R4
endmodule

bind evt_sample_buffer evb_checker #(.PW(PW), .DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .l2_accept  (l2_accept),
  .rd_en      (rd_en),
  .rd_avail   (rd_avail),
  .rd_valid   (rd_valid),
  .overflow   (overflow),
  .wr_q       (wr_q),
  .rd_q       (rd_q),
  .commit_q   (commit_q),
  .keep_q     (keep_q),
  .ev_commit  (ev_commit),
  .ev_discard (ev_discard),
  .ev_reject  (ev_reject),
  .data_wr    (data_wr),
  .hdr_wr     (hdr_wr)
);

// File: tb/evt_sample_buffer_tb.sv
module evt_sample_buffer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN   = 1008;
  localparam int DEPTH = 1024;
  localparam int NEED  = 1 + (WIN + 3) / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l1_trig = 1'b0, l2_accept = 1'b0, raw_mode = 1'b0;
  logic smp_valid = 1'b0, smp_suppressed = 1'b0, rd_en = 1'b0;
  logic [9:0]  smp_data = '0;
  logic        rd_avail, rd_valid, full, overflow;
  logic [39:0] rd_data;

  evt_sample_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .l1_trig(l1_trig), .l2_accept(l2_accept),
    .raw_mode(raw_mode), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_suppressed(smp_suppressed), .rd_en(rd_en), .rd_avail(rd_avail),
    .rd_valid(rd_valid), .rd_data(rd_data), .full(full), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int unsigned tb_cyc;
  always @(posedge clk) begin
    if (!rst_n) tb_cyc <= 0;
    else        tb_cyc <= tb_cyc + 1;
  end

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [39:0] exp_q[$];
  logic [39:0] pend_q[$];
  bit          pend_valid = 1'b0;
  int          used = 0;
  bit          ovf_exp = 1'b0;
  int unsigned ts_cap;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // header word followed by samples laid out slot by slot
  function automatic void build_words(input int unsigned ts, input logic [9:0] s[$],
                                      ref logic [39:0] w[$]);
    logic [39:0] hdr;
    int nwords;
    w.delete();
    hdr = ({10'd0, ts[29:0]} << 10) | 40'(s.size());
    w.push_back(hdr);
    nwords = (s.size() + 3) / 4;
    for (int k = 0; k < nwords; k++) begin
      logic [39:0] acc = '0;
      for (int j = 0; j < 4; j++)
        if (k*4 + j < s.size()) acc = acc | (40'(s[k*4 + j]) << (10*j));
      w.push_back(acc);
    end
  endfunction

  task automatic commit_pend();
    foreach (pend_q[i]) exp_q.push_back(pend_q[i]);
    used += pend_q.size();
    pend_q.delete();
    pend_valid = 1'b0;
  endtask

  task automatic trig(input bit with_l2, output bit started);
    @(negedge clk);
    if (pend_valid) begin
      if (with_l2) commit_pend();
      else begin pend_q.delete(); pend_valid = 1'b0; end
    end
    started = (DEPTH - used) >= NEED;
    if (!started) ovf_exp = 1'b1;
    ts_cap = tb_cyc;
    l1_trig = 1'b1;
    l2_accept = with_l2;
    @(negedge clk);
    l1_trig = 1'b0;
    l2_accept = 1'b0;
  endtask

  task automatic capture(input bit started, input bit raw, input int keep_pct, input int l2_at);
    logic [9:0] smp[$];
    raw_mode = raw;
    for (int i = 0; i < WIN; i++) begin
      while ($urandom_range(3) == 0) begin
        smp_valid = 1'b0;
        @(negedge clk);
      end
      smp_valid      = 1'b1;
      smp_data       = 10'($urandom);
      smp_suppressed = ($urandom_range(99) >= keep_pct);
      l2_accept      = (i == l2_at);
      if (started && (raw || !smp_suppressed)) smp.push_back(smp_data);
      @(negedge clk);
    end
    smp_valid = 1'b0;
    l2_accept = 1'b0;
    if (started) begin
      build_words(ts_cap, smp, pend_q);
      if (l2_at >= 0) commit_pend();
      else pend_valid = 1'b1;
    end
  endtask

  task automatic accept();
    @(negedge clk);
    l2_accept = 1'b1;
    @(negedge clk);
    l2_accept = 1'b0;
    commit_pend();
  endtask

  task automatic drain(input string req);
    logic [39:0] e;
    repeat (3) @(negedge clk);
    while (rd_avail) begin
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check(rd_valid === 1'b1, "R10", "rd_valid after rd_en", 64'(rd_valid), 64'd1);
      if (exp_q.size() == 0) begin
        check(1'b0, req, "extra word read", 64'(rd_data), 64'd0);
      end else begin
        e = exp_q.pop_front();
        used--;
        check(rd_data === e, req, "word content", 64'(rd_data), 64'(e));
      end
    end
    check(exp_q.size() == 0, req, "words left unread", 64'(exp_q.size()), 64'd0);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_valid === 1'b0, "R10", "rd_en with nothing available", 64'(rd_valid), 64'd0);
  endtask

  task automatic status(input string req);
    bit fexp = (DEPTH - used) < NEED;
    check(full === fexp, req, "full flag", 64'(full), 64'(fexp));
    check(overflow === ovf_exp, req, "overflow flag", 64'(overflow), 64'(ovf_exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit st;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(full === 1'b0, "R1", "full", 64'(full), 64'd0);
    check(overflow === 1'b0, "R1", "overflow", 64'(overflow), 64'd0);
    check(rd_avail === 1'b0, "R1", "rd_avail", 64'(rd_avail), 64'd0);
    check(rd_valid === 1'b0, "R1", "rd_valid", 64'(rd_valid), 64'd0);

    // R2 strobes with no trigger store nothing
    capture(1'b0, 1'b1, 100, -1);
    drain("R2");

    // R3 R4 R5 random streams, accept during capture (R6) or after
    for (int n = 0; n < 4; n++) begin
      bit raw = n[0];
      int pct = int'($urandom_range(100, 30));
      int at  = (n >= 2) ? int'($urandom_range(WIN-1)) : -1;
      trig(1'b0, st);
      capture(st, raw, pct, at);
      if (at < 0) accept();
      drain("R4");
    end

    // R7 pending stream is dropped by the next trigger
    trig(1'b0, st);
    capture(st, 1'b0, 60, -1);
    drain("R7");
    trig(1'b0, st);
    capture(st, 1'b1, 100, -1);
    accept();
    drain("R7");

    // R8 accept in the same cycle as the next trigger
    trig(1'b0, st);
    capture(st, 1'b0, 50, -1);
    trig(1'b1, st);
    capture(st, 1'b0, 70, -1);
    accept();
    drain("R8");

    // R4 R5 stream with no stored samples: header only, length 0
    trig(1'b0, st);
    capture(st, 1'b0, 0, 10);
    drain("R5");

    // R11 eight sparse streams held together
    for (int n = 0; n < 8; n++) begin
      trig(1'b0, st);
      capture(st, 1'b0, 20, -1);
      accept();
      status("R11");
    end
    drain("R11");

    // R9 R11 four full raw streams, then a refused trigger
    for (int n = 0; n < 4; n++) begin
      trig(1'b0, st);
      capture(st, 1'b1, 100, -1);
      accept();
    end
    @(negedge clk);
    status("R9");
    trig(1'b0, st);
    check(st == 1'b0, "R9", "bench expects refusal", 64'(st), 64'd0);
    capture(st, 1'b1, 100, 5);
    @(negedge clk);
    status("R9");
    drain("R11");
    status("R9");
    trig(1'b0, st);
    capture(st, 1'b0, 40, -1);
    accept();
    drain("R6");
    status("R9");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule